// File: doc/BRIEF.md
# Full-Frame CCD Readout Sequencer

This block produces the digital phase pattern that reads one frame out of a two-phase full-frame CCD. A start strobe begins a frame. Each line is first moved out of the image area by a four-state vertical transfer on V1/V2. The line is then clocked out of the horizontal register with complementary H1/H2 phases and one reset pulse R per pixel. The last horizontal gate is split into H21 and H22. Only one of them follows H2, and that choice steers charge to the low-noise amplifier or to the wide-range amplifier.

Alongside the phases, the block gives a one-cycle pixel strobe once each packet has been dumped onto the sense node. The strobe comes with the line and column numbers and a flag that says whether the pixel is imaging (active), dark reference, or inactive. The output choice, the horizontal quarter length and the vertical step length are captured when a frame starts and stay fixed for that whole frame. Both lengths are raised to safe minimums. A done pulse closes the frame.

Top module: `ccd_readout_seq`

## Requirements
- R1: Out of reset and while idle: V1=V2=0, H1=1, H2=0, H21=H22=0, R=0, pix_valid=0, done=0.
- R2: In the cycle after an accepted start edge, V1/V2 step through the states (1,0), (0,1), (1,0), (0,0). Each state lasts S clocks, where S = max(vstep, 4) is captured at the start.
- R3: While a vertical transfer runs, the horizontal clocks are parked at H1=1, H2=0, R=0. Horizontal readout of the line begins in the cycle right after the vertical state (0,0) ends.
- R4: A pixel slot is four quarters of Q clocks each. H2=1 and H1=0 for quarters 0 and 1; H1=1 and H2=0 for quarters 2 and 3. A line has LEAD+ACT+TRAIL_DARK+TRAIL_INACT slots (1036 by default).
- R5: R is high exactly during quarter 3 of each slot, so it never coincides with an H2 falling edge.
- R6: pix_valid is high for one clock, the first clock of quarter 2 (just after H2 falls). With it, col_o gives the 0-based slot index and row_o the 0-based line index.
- R7: A frame is TOP+ACT_LINES+BOT line transfers (1032 by default), each followed by one full line readout. Region flags are based on column c and line r. Columns c >= LEAD+ACT_COLS+TRAIL_DARK are inactive. Otherwise the pixel is dark when c < LEAD, c >= LEAD+ACT_COLS, r < TOP or r >= TOP+ACT_LINES. All other pixels are active. Exactly one flag is high with pix_valid, and all flags are low otherwise.
- R8: With out_sel=0 (wide-range output), H21 follows H2 and H22 stays 0. With out_sel=1 (low-noise output), H22 follows H2 and H21 stays 0. out_sel is sampled only at an accepted start.
- R9: Q = max(hdiv, QMIN), sampled at the start. QMIN is the smallest quarter that keeps the pixel rate at or below 5 MHz (out_sel=1) or 2 MHz (out_sel=0). At SYS_KHZ=50000 that gives QMIN=3 and QMIN=7 respectively.
- R10: A start is ignored while a frame is in progress or while integ_i is high.
- R11: done is a one-clock pulse in the cycle after the last clock of the last slot of the last line. The block is idle from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| integ_i | input | 1 | Integration in progress; blocks starts |
| out_sel_i | input | 1 | 0: wide-range output, 1: low-noise output |
| hdiv_i | input | DIV_W | Requested horizontal quarter length in clocks |
| vstep_i | input | VST_W | Requested vertical state length in clocks |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| h21_o | output | 1 | Split last gate, wide-range branch |
| h22_o | output | 1 | Split last gate, low-noise branch |
| r_o | output | 1 | Sense-node reset clock |
| pix_valid_o | output | 1 | Pixel strobe |
| row_o | output | ROW_W | Line index of the strobed pixel |
| col_o | output | COL_W | Column index of the strobed pixel |
| dark_o | output | 1 | Strobed pixel is dark reference |
| active_o | output | 1 | Strobed pixel is imaging |
| inactive_o | output | 1 | Strobed pixel is inactive |
| done_o | output | 1 | Frame complete pulse |

## Verification
Every result is due at a fixed clock offset from the edge that accepts the start strobe. The vertical states begin in the next cycle. A line lasts 4S plus 4Q times the column count. The pixel strobe falls 2Q clocks into each slot, and done follows the final slot by one clock. The monitor sets its time origin at the falling edge after the start edge. In every cycle it works out the expected phase levels from that offset and samples the outputs 1 ns after the falling clock edge. Each pixel strobe is matched against a queue of expected line, column and region entries that the driver fills before the frame starts.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  // vertical transfer states, in the order the phases visit them
  typedef enum logic [2:0] {
    VS_IDLE = 3'd0,
    VS_A    = 3'd1,   // V1 high, V2 low
    VS_B    = 3'd2,   // V1 low,  V2 high (line enters serial register)
    VS_C    = 3'd3,   // V1 high, V2 low
    VS_D    = 3'd4    // both low, closing state
  } vstate_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_VERT = 2'd1,
    FS_HORZ = 2'd2
  } fstate_e;

endpackage

// File: rtl/ccd_vert_seq.sv
module ccd_vert_seq
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] step_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             done_o
);

  vstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == VS_IDLE) begin
      if (go_i) begin
        st_d  = VS_A;
        cnt_d = step_i - CNT_W'(1);
      end
    end else if (cnt_q == '0) begin
      cnt_d = step_i - CNT_W'(1);
      case (st_q)
        VS_A:    st_d = VS_B;
        VS_B:    st_d = VS_C;
        VS_C:    st_d = VS_D;
        default: st_d = VS_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= VS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign v1_o   = (st_q == VS_A) || (st_q == VS_C);
  assign v2_o   = (st_q == VS_B);
  assign done_o = (st_q == VS_D) && (cnt_q == '0);

  // R2: V2 only rises out of the V1-high state
  a_r2_v2_rise_after_v1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v2_o) |-> $past(v1_o));

  // R2: both phases are low once the sequence has closed
  a_r2_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!v1_o && !v2_o));

  // R2: a state is held until its count runs out
  a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != VS_IDLE && cnt_q != '0) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/ccd_horiz_seq.sv
module ccd_horiz_seq #(
  parameter int NCOL  = 1036,
  parameter int COL_W = 11,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [Q_W-1:0]   q_i,
  output logic             h1_o,
  output logic             h2_o,
  output logic             r_o,
  output logic             pix_o,
  output logic [COL_W-1:0] col_o,
  output logic             done_o
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOL - 1);

  logic             busy_q, busy_d;
  logic [1:0]       qtr_q, qtr_d;
  logic [Q_W-1:0]   qcnt_q, qcnt_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [Q_W-1:0]   q_top;

  assign q_top = q_i - Q_W'(1);

  always_comb begin
    busy_d = busy_q;
    qtr_d  = qtr_q;
    qcnt_d = qcnt_q;
    col_d  = col_q;
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1;
        qtr_d  = 2'd0;
        qcnt_d = q_top;
        col_d  = '0;
      end
    end else if (qcnt_q == '0) begin
      qcnt_d = q_top;
      qtr_d  = qtr_q + 2'd1;
      if (qtr_q == 2'd3) begin
        if (col_q == LAST_COL) begin
          busy_d = 1'b0;
        end else begin
          col_d = col_q + COL_W'(1);
        end
      end
    end else begin
      qcnt_d = qcnt_q - Q_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      qtr_q  <= 2'd0;
      qcnt_q <= '0;
      col_q  <= '0;
    end else begin
      busy_q <= busy_d;
      qtr_q  <= qtr_d;
      qcnt_q <= qcnt_d;
      col_q  <= col_d;
    end
  end

  assign h2_o   = busy_q && !qtr_q[1];
  assign h1_o   = !h2_o;
  assign r_o    = busy_q && (qtr_q == 2'd3);
  assign pix_o  = busy_q && (qtr_q == 2'd2) && (qcnt_q == q_top);
  assign col_o  = col_q;
  assign done_o = busy_q && (qtr_q == 2'd3) && (qcnt_q == '0) && (col_q == LAST_COL);

  // R6: the pixel strobe coincides with the H2 falling edge cycle
  a_r6_pix_on_h2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    pix_o |-> $fell(h2_o));

  // R5: the reset clock is never high at an H2 fall
  a_r5_r_clear_of_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h2_o) |-> !r_o);

  // R5: R rises only after H1 has already been high
  a_r5_r_after_h1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_o) |-> $past(h1_o));

endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map #(
  parameter int LEAD_COLS   = 4,
  parameter int ACT_COLS    = 1024,
  parameter int TRAIL_DARK  = 4,
  parameter int TOP_LINES   = 4,
  parameter int ACT_LINES   = 1024,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 11
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             dark_o,
  output logic             active_o,
  output logic             inactive_o
);

  localparam logic [COL_W:0] C_ACT_LO = (COL_W+1)'(LEAD_COLS);
  localparam logic [COL_W:0] C_ACT_HI = (COL_W+1)'(LEAD_COLS + ACT_COLS);
  localparam logic [COL_W:0] C_INACT  = (COL_W+1)'(LEAD_COLS + ACT_COLS + TRAIL_DARK);
  localparam logic [ROW_W:0] R_ACT_LO = (ROW_W+1)'(TOP_LINES);
  localparam logic [ROW_W:0] R_ACT_HI = (ROW_W+1)'(TOP_LINES + ACT_LINES);

  logic [COL_W:0] col_x;
  logic [ROW_W:0] row_x;
  logic           col_dark, row_dark;

  assign col_x      = {1'b0, col_i};
  assign row_x      = {1'b0, row_i};
  assign col_dark   = (col_x < C_ACT_LO) || (col_x >= C_ACT_HI);
  assign row_dark   = (row_x < R_ACT_LO) || (row_x >= R_ACT_HI);
  assign inactive_o = (col_x >= C_INACT);
  assign dark_o     = !inactive_o && (col_dark || row_dark);
  assign active_o   = !inactive_o && !col_dark && !row_dark;

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int LEAD_COLS   = 4,
  parameter int ACT_COLS    = 1024,
  parameter int TRAIL_DARK  = 4,
  parameter int TRAIL_INACT = 4,
  parameter int TOP_LINES   = 4,
  parameter int ACT_LINES   = 1024,
  parameter int BOT_LINES   = 4,
  parameter int SYS_KHZ     = 50000,
  parameter int DIV_W       = 8,
  parameter int VST_W       = 8,
  localparam int NCOL  = LEAD_COLS + ACT_COLS + TRAIL_DARK + TRAIL_INACT,
  localparam int NROW  = TOP_LINES + ACT_LINES + BOT_LINES,
  localparam int COL_W = $clog2(NCOL),
  localparam int ROW_W = $clog2(NROW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             integ_i,
  input  logic             out_sel_i,
  input  logic [DIV_W-1:0] hdiv_i,
  input  logic [VST_W-1:0] vstep_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             h21_o,
  output logic             h22_o,
  output logic             r_o,
  output logic             pix_valid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             dark_o,
  output logic             active_o,
  output logic             inactive_o,
  output logic             done_o
);

  // smallest quarter length that keeps each output within its pixel rate
  localparam int PER_FAST  = (SYS_KHZ + 4999) / 5000;
  localparam int PER_SLOW  = (SYS_KHZ + 1999) / 2000;
  localparam int QMIN_FAST = (PER_FAST + 3) / 4;
  localparam int QMIN_SLOW = (PER_SLOW + 3) / 4;
  localparam logic [DIV_W-1:0] QMIN_FAST_V = DIV_W'(QMIN_FAST);
  localparam logic [DIV_W-1:0] QMIN_SLOW_V = DIV_W'(QMIN_SLOW);
  localparam logic [VST_W-1:0] VMIN_V      = VST_W'(4);
  localparam logic [ROW_W-1:0] LAST_ROW    = ROW_W'(NROW - 1);

  fstate_e          fs_q, fs_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             sel_q;
  logic [DIV_W-1:0] q_q;
  logic [VST_W-1:0] vst_q;
  logic             done_q, done_d;

  logic             start_acc;
  logic [DIV_W-1:0] q_min, q_new;
  logic [VST_W-1:0] vst_new, vst_use;
  logic             vgo, hgo, vdone, hdone;
  logic             h2_w, pix_w;
  logic             dark_w, act_w, inact_w;

  assign start_acc = start_i && !integ_i && (fs_q == FS_IDLE);
  assign q_min     = out_sel_i ? QMIN_FAST_V : QMIN_SLOW_V;
  assign q_new     = (hdiv_i < q_min) ? q_min : hdiv_i;
  assign vst_new   = (vstep_i < VMIN_V) ? VMIN_V : vstep_i;
  // the first transfer loads its count in the same edge as the config
  assign vst_use   = (fs_q == FS_IDLE) ? vst_new : vst_q;

  // frame controller next state
  always_comb begin
    fs_d   = fs_q;
    row_d  = row_q;
    done_d = 1'b0;
    vgo    = 1'b0;
    hgo    = 1'b0;
    case (fs_q)
      FS_IDLE: begin
        if (start_acc) begin
          fs_d  = FS_VERT;
          row_d = '0;
          vgo   = 1'b1;
        end
      end
      FS_VERT: begin
        if (vdone) begin
          fs_d = FS_HORZ;
          hgo  = 1'b1;
        end
      end
      FS_HORZ: begin
        if (hdone) begin
          if (row_q == LAST_ROW) begin
            fs_d   = FS_IDLE;
            done_d = 1'b1;
          end else begin
            fs_d  = FS_VERT;
            row_d = row_q + ROW_W'(1);
            vgo   = 1'b1;
          end
        end
      end
      default: fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= FS_IDLE;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      row_q  <= row_d;
      done_q <= done_d;
    end
  end

  // frame configuration, loaded only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      q_q   <= QMIN_SLOW_V;
      vst_q <= VMIN_V;
    end else if (start_acc) begin
      sel_q <= out_sel_i;
      q_q   <= q_new;
      vst_q <= vst_new;
    end
  end

  ccd_vert_seq #(
    .CNT_W (VST_W)
  ) u_vert (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (vgo),
    .step_i (vst_use),
    .v1_o   (v1_o),
    .v2_o   (v2_o),
    .done_o (vdone)
  );

  ccd_horiz_seq #(
    .NCOL  (NCOL),
    .COL_W (COL_W),
    .Q_W   (DIV_W)
  ) u_horiz (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (hgo),
    .q_i    (q_q),
    .h1_o   (h1_o),
    .h2_o   (h2_w),
    .r_o    (r_o),
    .pix_o  (pix_w),
    .col_o  (col_o),
    .done_o (hdone)
  );

  ccd_region_map #(
    .LEAD_COLS  (LEAD_COLS),
    .ACT_COLS   (ACT_COLS),
    .TRAIL_DARK (TRAIL_DARK),
    .TOP_LINES  (TOP_LINES),
    .ACT_LINES  (ACT_LINES),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W)
  ) u_region (
    .row_i      (row_q),
    .col_i      (col_o),
    .dark_o     (dark_w),
    .active_o   (act_w),
    .inactive_o (inact_w)
  );

  // split last gate: only the selected branch follows H2
  assign h2_o        = h2_w;
  assign h21_o       = sel_q ? 1'b0 : h2_w;
  assign h22_o       = sel_q ? h2_w : 1'b0;
  assign pix_valid_o = pix_w;
  assign dark_o      = pix_w && dark_w;
  assign active_o    = pix_w && act_w;
  assign inactive_o  = pix_w && inact_w;
  assign row_o       = row_q;
  assign done_o      = done_q;

  // R3: serial clocks are parked while a vertical transfer runs
  a_r3_parked_in_vert: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q == FS_VERT) |-> (h1_o && !h2_o && !r_o));

  // R8: the output choice stays fixed within a frame
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q != FS_IDLE && $past(fs_q) != FS_IDLE) |-> $stable(sel_q));

  // R9: the running quarter length honours the selected output's limit
  a_r9_rate_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q != FS_IDLE) |-> (q_q >= (sel_q ? QMIN_FAST_V : QMIN_SLOW_V)));

  // R7: exactly one region flag accompanies each pixel strobe
  a_r7_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> ($countones({dark_o, active_o, inactive_o}) == 1));

  // R11: done only appears once the block has gone idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fs_q == FS_IDLE && !v1_o && !v2_o && !h2_o));

endmodule

// File: tb/test_ccd_readout_seq.sv
`timescale 1ns/1ps
module test_ccd_readout_seq;

  localparam int LC = 2, AC = 3, TD = 1, TI = 1;
  localparam int TL = 1, AL = 2, BL = 1;
  localparam int NCOL = LC + AC + TD + TI;
  localparam int NROW = TL + AL + BL;
  localparam int CW = $clog2(NCOL);
  localparam int RW = $clog2(NROW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, integ_i, out_sel_i;
  logic [7:0]    hdiv_i, vstep_i;
  logic          v1_o, v2_o, h1_o, h2_o, h21_o, h22_o, r_o;
  logic          pix_valid_o, dark_o, active_o, inactive_o, done_o;
  logic [RW-1:0] row_o;
  logic [CW-1:0] col_o;

  always #10 clk = ~clk;

  ccd_readout_seq #(
    .LEAD_COLS (LC), .ACT_COLS (AC), .TRAIL_DARK (TD), .TRAIL_INACT (TI),
    .TOP_LINES (TL), .ACT_LINES (AL), .BOT_LINES (BL)
  ) i_ccd_readout_seq (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .integ_i (integ_i),
    .out_sel_i (out_sel_i), .hdiv_i (hdiv_i), .vstep_i (vstep_i),
    .v1_o (v1_o), .v2_o (v2_o), .h1_o (h1_o), .h2_o (h2_o),
    .h21_o (h21_o), .h22_o (h22_o), .r_o (r_o), .pix_valid_o (pix_valid_o),
    .row_o (row_o), .col_o (col_o), .dark_o (dark_o), .active_o (active_o),
    .inactive_o (inactive_o), .done_o (done_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // frame model, written by the driver only
  int fstart = 0, flen = 0, fS = 4, fQ = 7, fsel = 0;
  bit have = 1'b0;

  typedef struct { int row; int col; int rg; } pix_t;
  pix_t expq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // R7 region code: 0 active, 1 dark, 2 inactive
  function automatic int region(input int r, input int c);
    if (c >= LC + AC + TD) return 2;
    if (c < LC || c >= LC + AC || r < TL || r >= TL + AL) return 1;
    return 0;
  endfunction

  task automatic run_frame(input int sel, input int hdiv, input int vs, input bit disturb);
    int qmin, qe, se;
    qmin = sel ? 3 : 7;                 // R9 at 50 MHz system clock
    qe   = (hdiv < qmin) ? qmin : hdiv;
    se   = (vs < 4) ? 4 : vs;           // R2 minimum step
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        pix_t p;
        p.row = r; p.col = c; p.rg = region(r, c);
        expq.push_back(p);
      end
    @(negedge clk);
    out_sel_i = sel[0]; hdiv_i = 8'(hdiv); vstep_i = 8'(vs); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    fS = se; fQ = qe; fsel = sel;
    flen = NROW * (4 * se + NCOL * 4 * qe);
    fstart = cyc;
    have = 1'b1;
    if (disturb) begin
      // R10: a second start mid-frame with new settings must change nothing
      repeat (30) @(negedge clk);
      out_sel_i = ~sel[0]; hdiv_i = 8'd1; vstep_i = 8'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (cyc - fstart <= flen + 1) @(negedge clk);
    chk(expq.size() == 0, "R7", expq.size(), 0, "pixels not delivered");
    expq.delete();
  endtask

  // monitor: per-cycle phase model plus pixel scoreboard
  always begin
    int t, L, u, w, p, qq;
    bit ev1, ev2, eh2, er, epix, edone, eh21, eh22;
    string tv, th;
    @(negedge clk);
    #1;
    if (rst_n) begin
      t = have ? (cyc - fstart) : -1;
      ev1 = 0; ev2 = 0; eh2 = 0; er = 0; epix = 0; edone = 0;
      tv = "R1"; th = "R1";
      if (have && t >= 0 && t < flen) begin
        L = 4 * fS + NCOL * 4 * fQ;
        u = t % L;
        tv = "R2";
        if (u < 4 * fS) begin
          ev1 = ((u / fS) == 0) || ((u / fS) == 2);
          ev2 = ((u / fS) == 1);
          th  = "R3";
        end else begin
          w  = u - 4 * fS;
          p  = w % (4 * fQ);
          qq = p / fQ;
          eh2  = (qq < 2);
          er   = (qq == 3);
          epix = (p == 2 * fQ);
          th   = "R4";
        end
      end else if (have && t == flen) begin
        edone = 1'b1;
      end
      eh21 = fsel ? 1'b0 : eh2;
      eh22 = fsel ? eh2 : 1'b0;
      chk(v1_o == ev1 && v2_o == ev2, tv, int'({v1_o, v2_o}), int'({ev1, ev2}), "V1V2");
      chk(h1_o == !eh2 && h2_o == eh2, th, int'({h1_o, h2_o}), int'({!eh2, eh2}), "H1H2");
      chk(r_o == er, "R5", int'(r_o), int'(er), "R clock");
      chk(h21_o == eh21 && h22_o == eh22, "R8", int'({h21_o, h22_o}), int'({eh21, eh22}), "H21H22");
      chk(pix_valid_o == epix, "R6", int'(pix_valid_o), int'(epix), "pixel strobe");
      chk(done_o == edone, "R11", int'(done_o), int'(edone), "done");
      if (!pix_valid_o) begin
        chk({dark_o, active_o, inactive_o} == 3'b000, "R7", int'({dark_o, active_o, inactive_o}), 0, "flags idle");
      end else if (expq.size() == 0) begin
        chk(1'b0, "R6", int'(col_o), -1, "unexpected pixel");
      end else begin
        pix_t e;
        int grc;
        e = expq.pop_front();
        grc = active_o ? 0 : dark_o ? 1 : inactive_o ? 2 : 3;
        chk(int'(row_o) == e.row, "R6", int'(row_o), e.row, "row index");
        chk(int'(col_o) == e.col, "R6", int'(col_o), e.col, "col index");
        chk(grc == e.rg, "R7", grc, e.rg, "region");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; integ_i = 1'b0; out_sel_i = 1'b0;
    hdiv_i = 8'd7; vstep_i = 8'd4;
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(!v1_o && !v2_o, "R1", int'({v1_o, v2_o}), 0, "reset V");
    chk(h1_o && !h2_o, "R1", int'({h1_o, h2_o}), 2, "reset H");
    chk(!h21_o && !h22_o && !r_o, "R1", int'({h21_o, h22_o, r_o}), 0, "reset gates");
    chk(!pix_valid_o && !done_o, "R1", int'({pix_valid_o, done_o}), 0, "reset strobes");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: start while integrating is ignored
    integ_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(!v1_o && !v2_o && h1_o, "R10", int'({v1_o, v2_o, h1_o}), 1, "start under integration");
    integ_i = 1'b0;
    repeat (3) @(negedge clk);

    run_frame(0, 2, 1, 1'b0);   // R9 clamp to 7, R2 clamp to 4, R8 wide-range
    run_frame(1, 3, 5, 1'b1);   // R8 low-noise, R10 mid-frame start ignored
    run_frame(1, 1, 4, 1'b0);   // R9 clamp to 3
    run_frame(0, 9, 6, 1'b0);   // R4 longer quarters, R2 longer steps

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule